// File: doc/BRIEF.md
# Offset-Throttled Synchronous Bus Sender

This block is the target-side transmitter for a synchronous parallel data phase toward the initiator. It takes bytes from a valid/ready stream and places each one on an 8-bit data bus, marking it with a single REQ pulse. The initiator does not answer each byte before the next one goes out. Instead, the initiator's ACK pulses are counted afterwards. A start strobe loads a 16-bit down-counter with the transfer length. Every falling edge of the synchronized ACK line lowers that counter by one.

The sender keeps the number of unacknowledged bytes within the negotiated offset. Before it drives a byte, it compares the ACK counter with the number of bytes that will still be left after that byte. Each byte has two equal phases: a setup phase after the data changes and a REQ-high phase. The length of each phase comes from the period setting. After the final pulse, the data stays on the bus for one more phase before it is released. The transfer then finishes only when every ACK has come back.

A bus-reset input cancels the transfer at once. Any wait ends, whether it is for offset room or for the final ACKs, and an aborted flag is set.

Top module: `sync_tx_throttle`

## Requirements
- R1: While rst_n is low, and after reset until a start, in_ready, bus_req, bus_data_oe, busy, done and aborted are all 0, and bus_data is 0.
- R2: A start accepted while idle loads the ACK counter with xfer_len. The counter drops by exactly one for each high-to-low transition of bus_ack, seen after a two-flop synchronizer. A high level alone gives no credit, and the counter stops at zero without wrapping.
- R3: Byte number k (counting from 1) is driven only when the ACK counter is at most (xfer_len − k) + offset. If the initiator has returned a ACK pulses, exactly min(xfer_len, a + offset) REQ pulses appear.
- R4: The phase length is N = max(1, ceil(cfg_period·2 ns / CLK_NS)) clock cycles. After a byte is taken, bus_data holds it for N cycles with bus_req low, and then bus_req is high for N cycles while bus_data stays stable.
- R5: Bytes are taken from in_data only when in_valid and in_ready are both high. They appear on bus_data in stream order, with one bus_req pulse each, and bus_req is high only while bus_data_oe is high.
- R6: After the falling edge of the last REQ pulse, bus_data_oe stays high for N more cycles. It then goes low, and bus_data returns to 0.
- R7: done is a pulse of exactly one cycle. It is raised only after all bytes have been sent and the ACK counter is zero. busy stays high until that cycle and is low from that cycle onward.
- R8: While busy, a high bus_rst makes busy, bus_req and bus_data_oe 0 on the next cycle and sets aborted, with no done pulse. aborted stays 1 until the next accepted start.
- R9: A start with xfer_len = 0 drives no REQ pulse, raises done once, and clears aborted.
- R10: A start pulse that arrives while busy is ignored. The running transfer keeps its original length and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | 8 | Transfer period in 4 ns units, captured at start |
| cfg_offset | input | 5 | Maximum unacknowledged bytes, captured at start |
| xfer_len | input | 16 | Number of bytes to send, captured at start |
| start | input | 1 | Begin a transfer (used only while idle) |
| bus_rst | input | 1 | Bus reset; aborts a running transfer |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Sender takes in_data this cycle |
| bus_ack | input | 1 | Asynchronous ACK line from the initiator; falling edges count |
| bus_data | output | 8 | Data driven toward the bus |
| bus_data_oe | output | 1 | Data-bus drive enable |
| bus_req | output | 1 | REQ strobe, one pulse per byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| aborted | output | 1 | Last transfer ended by bus reset |

## Verification
The hardest situations to reach are the stalls. In one, the sender sits exactly at the offset limit. In the other, every byte has been sent but ACKs are still missing. Both only happen if the initiator holds back its ACK pulses. The bench's initiator model therefore hands out ACKs from a budget that a test can freeze, release a few at a time, or switch to manual control. Manual control lets the ACK line be held high for a long time before it falls. With this, a test can show that exactly offset + ACKs bytes leave the sender, that only a falling edge earns credit, and that a bus reset ends either stall.

// File: rtl/sync_tx_pkg.sv
`timescale 1ns/1ps
// Shared types for the synchronous sender.
package sync_tx_pkg;

    // Sequencer states of the sender.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for start
        ST_ROOM  = 3'd1,  // waiting for offset room and a stream byte
        ST_SETUP = 3'd2,  // data on bus, REQ low
        ST_PULSE = 3'd3,  // REQ high
        ST_TAIL  = 3'd4,  // hold data one phase after the last pulse
        ST_DRAIN = 3'd5   // waiting for the ACK counter to reach zero
    } tx_state_t;

endpackage

// File: rtl/sync_ack_tally.sv
`timescale 1ns/1ps
// ACK tally: brings the asynchronous ACK line through two flops, detects
// falling edges and counts them down from a loaded value.
// Assumes ACK pulses and gaps each last at least two clock cycles.
// The count saturates at zero.
module sync_ack_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_async,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             count_zero
);

    logic sync_a;
    logic sync_b;
    logic ack_prev;
    logic ack_fall;

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            ack_prev <= 1'b0;
        end else begin
            sync_a   <= ack_async;
            sync_b   <= sync_a;
            ack_prev <= sync_b;
        end
    end

    // A high-to-low transition of the synchronized line.
    assign ack_fall = ack_prev & ~sync_b;

    // Down-counter: loaded on start, lowered by one per falling edge, held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (ack_fall && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    assign count_zero = (count == '0);

    AST_TALLY_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> (count == '0)); // R2

    AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((count == $past(count)) || (count == $past(count) - 1'b1))); // R2

endmodule

// File: rtl/sync_phase_timer.sv
`timescale 1ns/1ps
// Phase timer: converts the period setting into a phase length in clock cycles
// and counts one phase after each load.
// Each phase is period*2 ns, rounded up to whole clocks, and at least one cycle.
// expired is high in the last cycle of a phase.
module sync_phase_timer #(
    parameter int PERIOD_W = 8,
    parameter int CLK_NS   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                load,
    output logic                expired
);

    localparam int PH_W = PERIOD_W + $clog2(CLK_NS + 1) + 2;

    logic [PH_W-1:0] scaled_ns;
    logic [PH_W-1:0] raw_cycles;
    logic [PH_W-1:0] half_cycles;
    logic [PH_W-1:0] cnt;

    // Phase length in cycles: ceil(period*2 / CLK_NS), at least 1.
    always_comb begin
        scaled_ns   = PH_W'({period, 1'b0}) + PH_W'(CLK_NS - 1);
        raw_cycles  = scaled_ns / PH_W'(CLK_NS);
        half_cycles = (raw_cycles == '0) ? PH_W'(1) : raw_cycles;
    end

    // Countdown of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= half_cycles - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sync_tx_throttle.sv
`timescale 1ns/1ps
// Offset-throttled synchronous sender.
// Drives one byte per REQ pulse toward the initiator without per-byte handshake,
// keeps unacknowledged bytes within the negotiated offset, and finishes once the
// ACK tally is zero. Assumes period, offset and length are stable at start (they
// are captured) and that bus_ack is asynchronous with pulses >= 2 clocks.
module sync_tx_throttle
    import sync_tx_pkg::*;
#(
    parameter int CLK_NS   = 5,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8,
    parameter int PERIOD_W = 8,
    parameter int OFFSET_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [OFFSET_W-1:0] cfg_offset,
    input  logic [CNT_W-1:0]    xfer_len,
    input  logic                start,
    input  logic                bus_rst,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                bus_ack,
    output logic [DATA_W-1:0]   bus_data,
    output logic                bus_data_oe,
    output logic                bus_req,
    output logic                busy,
    output logic                done,
    output logic                aborted
);

    localparam int CMP_W = CNT_W + 1;

    tx_state_t           state;
    logic [CNT_W-1:0]    remain;
    logic [PERIOD_W-1:0] period_q;
    logic [OFFSET_W-1:0] offset_q;
    logic [CNT_W-1:0]    ack_cnt;
    logic                ack_zero;
    logic                accept;
    logic                room;
    logic                take;
    logic                abort;
    logic                ph_load;
    logic                ph_exp;
    logic [CMP_W-1:0]    limit;

    // ACK tally instance.
    sync_ack_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_async  (bus_ack),
        .load       (accept),
        .load_val   (xfer_len),
        .count      (ack_cnt),
        .count_zero (ack_zero)
    );

    // Phase timer instance.
    sync_phase_timer #(.PERIOD_W(PERIOD_W), .CLK_NS(CLK_NS)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period_q),
        .load    (ph_load),
        .expired (ph_exp)
    );

    // Offset room: the tally must not exceed bytes left after this one plus offset.
    always_comb begin
        limit = ({1'b0, remain} - CMP_W'(1)) + CMP_W'(offset_q);
        room  = ({1'b0, ack_cnt} <= limit);
    end

    // Handshake and control strobes.
    always_comb begin
        accept   = start && (state == ST_IDLE);
        in_ready = (state == ST_ROOM) && room;
        take     = in_ready && in_valid;
        abort    = bus_rst && (state != ST_IDLE);
        ph_load  = take || (((state == ST_SETUP) || (state == ST_PULSE)) && ph_exp);
        busy     = (state != ST_IDLE);
    end

    // Sequencer: byte pacing, REQ pulses, tail hold, drain and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            remain      <= '0;
            period_q    <= '0;
            offset_q    <= '0;
            bus_data    <= '0;
            bus_data_oe <= 1'b0;
            bus_req     <= 1'b0;
            done        <= 1'b0;
            aborted     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state       <= ST_IDLE;
                bus_req     <= 1'b0;
                bus_data_oe <= 1'b0;
                bus_data    <= '0;
                aborted     <= 1'b1;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            period_q <= cfg_period;
                            offset_q <= cfg_offset;
                            remain   <= xfer_len;
                            aborted  <= 1'b0;
                            state    <= (xfer_len == '0) ? ST_DRAIN : ST_ROOM;
                        end
                    end
                    ST_ROOM: begin
                        if (take) begin
                            bus_data    <= in_data;
                            bus_data_oe <= 1'b1;
                            remain      <= remain - 1'b1;
                            state       <= ST_SETUP;
                        end
                    end
                    ST_SETUP: begin
                        if (ph_exp) begin
                            bus_req <= 1'b1;
                            state   <= ST_PULSE;
                        end
                    end
                    ST_PULSE: begin
                        if (ph_exp) begin
                            bus_req <= 1'b0;
                            state   <= (remain == '0) ? ST_TAIL : ST_ROOM;
                        end
                    end
                    ST_TAIL: begin
                        if (ph_exp) begin
                            bus_data_oe <= 1'b0;
                            bus_data    <= '0;
                            state       <= ST_DRAIN;
                        end
                    end
                    ST_DRAIN: begin
                        if (ack_zero) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_REQ_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_data_oe); // R5

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $stable(bus_data)); // R4

    AST_OFFSET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ({1'b0, ack_cnt} <= ({1'b0, remain} + CMP_W'(offset_q)))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ack_zero) && !busy)); // R7

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && busy) |=> (!busy && !bus_req && !bus_data_oe && aborted && !done)); // R8

endmodule

// File: tb/sync_tx_throttle_bench.sv
`timescale 1ns/1ps
// Directed bench: an initiator model returns ACK pulses from a budget; each task checks its scenario.
module sync_tx_throttle_bench;

    localparam int CLK_NS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_period = '0;
    logic [4:0] cfg_offset = '0;
    logic [15:0] xfer_len = '0;
    logic       start = 1'b0;
    logic       bus_rst = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b1;
    logic       in_ready;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_data;
    logic       bus_data_oe;
    logic       bus_req;
    logic       busy;
    logic       done;
    logic       aborted;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sync_tx_throttle #(.CLK_NS(CLK_NS)) u_sync_tx_throttle (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
        .xfer_len(xfer_len), .start(start), .bus_rst(bus_rst), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .bus_ack(bus_ack), .bus_data(bus_data),
        .bus_data_oe(bus_data_oe), .bus_req(bus_req), .busy(busy), .done(done),
        .aborted(aborted)
    );

    function automatic logic [7:0] pat(input int sd, input int i);
        return 8'((sd * 7 + i * 29 + 3) & 255);
    endfunction

    function automatic int exp_half(input int p);
        int r;
        r = (p * 2 + CLK_NS - 1) / CLK_NS;
        return (r < 1) ? 1 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Initiator model and stream source state.
    logic [7:0] rx_buf [0:63];
    int  rx_cnt = 0, acks_sent = 0, ack_budget = 0, ack_hi = 0, ack_gap = 0;
    bit  ack_manual = 0, hs_pending = 0;
    int  src_idx = 0, seed = 0;
    int  setup_cnt = 0, setup_len = 0, hi_cnt = 0, hi_len = 0, tail_cnt = 0, tail_len = 0;
    int  done_cycles = 0;
    logic req_prev = 0, oe_prev = 0;

    // Monitor, stream source and ACK generator, all at the falling clock edge.
    initial forever begin
        @(negedge clk);
        if (hs_pending) begin
            src_idx++;
            in_data = pat(seed, src_idx);
            setup_cnt = 1;
        end else begin
            setup_cnt++;
        end
        hs_pending = in_valid && in_ready;
        if (bus_req && !req_prev) begin
            rx_buf[rx_cnt % 64] = bus_data;
            rx_cnt++;
            setup_len = setup_cnt - 1;
            hi_cnt = 0;
            tail_cnt = 0;
        end
        if (bus_req) hi_cnt++;
        if (!bus_req && req_prev) hi_len = hi_cnt;
        if (bus_data_oe && !bus_req) tail_cnt++;
        if (!bus_data_oe && oe_prev) tail_len = tail_cnt;
        req_prev = bus_req;
        oe_prev = bus_data_oe;
        if (done) done_cycles++;
        if (!ack_manual) begin
            if (ack_hi > 0) begin
                ack_hi--;
                if (ack_hi == 0) begin
                    bus_ack = 1'b0;
                    ack_gap = 2;
                end
            end else if (ack_gap > 0) begin
                ack_gap--;
            end else if (acks_sent < ack_budget && acks_sent < rx_cnt) begin
                bus_ack = 1'b1;
                ack_hi = 2;
                acks_sent++;
            end
        end
    end

    task automatic go(input int len, input int per, input int off, input int sd, input int budget);
        @(negedge clk);
        seed = sd;
        src_idx = 0;
        in_data = pat(sd, 0);
        rx_cnt = 0;
        acks_sent = 0;
        ack_budget = budget;
        done_cycles = 0;
        xfer_len = 16'(len);
        cfg_period = 8'(per);
        cfg_offset = 5'(off);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input int maxc);
        for (int i = 0; i < maxc && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_data(input int n, input int sd, input string req);
        for (int i = 0; i < n; i++)
            chk(rx_buf[i] == pat(sd, i), req, int'(rx_buf[i]), int'(pat(sd, i)));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!in_ready && !bus_req && !bus_data_oe && !busy && !done && !aborted && bus_data == 0,
            "R1 outputs in reset", {in_ready, bus_req, bus_data_oe, busy, done, aborted}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !bus_data_oe && !done, "R1 idle after reset",
            {busy, bus_req, bus_data_oe, done}, 0);
    endtask

    task automatic t_basic(input int per, input int len, input int sd);
        int n;
        n = exp_half(per);
        go(len, per, 15, sd, 1000);
        wait_idle(20000);
        chk(rx_cnt == len, "R5 pulse count", rx_cnt, len);
        check_data(len, sd, "R5 byte order/value");
        chk(setup_len == n, "R4 setup phase", setup_len, n);
        chk(hi_len == n, "R4 REQ high phase", hi_len, n);
        chk(tail_len == n, "R6 tail hold", tail_len, n);
        chk(!bus_data_oe && bus_data == 0, "R6 release", {bus_data_oe, bus_data}, 0);
        chk(done_cycles == 1, "R7 done width", done_cycles, 1);
        chk(!aborted, "R7 no abort", aborted, 0);
    endtask

    task automatic t_throttle();
        go(10, 1, 3, 11, 0);
        repeat (100) @(negedge clk);
        chk(rx_cnt == 3, "R3 stall at offset", rx_cnt, 3);
        chk(busy == 1, "R3 still busy", busy, 1);
        ack_budget = 2;
        repeat (100) @(negedge clk);
        chk(rx_cnt == 5, "R3 credit from two acks", rx_cnt, 5);
        ack_budget = 1000;
        wait_idle(5000);
        chk(rx_cnt == 10, "R3 full transfer", rx_cnt, 10);
        check_data(10, 11, "R5 data after stall");
        chk(done_cycles == 1, "R7 done after stall", done_cycles, 1);
    endtask

    task automatic t_fall_edge();
        ack_manual = 1;
        bus_ack = 1'b0;
        go(4, 1, 1, 5, 0);
        repeat (40) @(negedge clk);
        chk(rx_cnt == 1, "R3 offset one", rx_cnt, 1);
        bus_ack = 1'b1;
        repeat (40) @(negedge clk);
        chk(rx_cnt == 1, "R2 high level gives no credit", rx_cnt, 1);
        bus_ack = 1'b0;
        repeat (40) @(negedge clk);
        chk(rx_cnt == 2, "R2 falling edge credit", rx_cnt, 2);
        for (int i = 0; i < 3; i++) begin
            bus_ack = 1'b1;
            repeat (4) @(negedge clk);
            bus_ack = 1'b0;
            repeat (30) @(negedge clk);
        end
        wait_idle(2000);
        chk(rx_cnt == 4 && done_cycles == 1, "R2 counted to zero", rx_cnt * 10 + done_cycles, 41);
        ack_manual = 0;
    endtask

    task automatic t_drain();
        go(3, 1, 8, 6, 1);
        repeat (100) @(negedge clk);
        chk(rx_cnt == 3, "R7 all bytes sent", rx_cnt, 3);
        chk(busy == 1 && done_cycles == 0, "R7 waits for acks", busy * 10 + done_cycles, 10);
        ack_budget = 1000;
        wait_idle(2000);
        chk(done_cycles == 1 && !busy, "R7 done after drain", done_cycles, 1);
    endtask

    task automatic t_abort(input int len, input int off, input int sent, input string tag);
        go(len, 1, off, 8, 0);
        repeat (80) @(negedge clk);
        chk(rx_cnt == sent && busy, {tag, " stalled before reset"}, rx_cnt, sent);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk(!busy && !bus_req && !bus_data_oe && aborted,
            {tag, " released on bus reset"}, {busy, bus_req, bus_data_oe, aborted}, 1);
        repeat (20) @(negedge clk);
        chk(done_cycles == 0 && aborted, {tag, " no done, aborted held"}, done_cycles, 0);
    endtask

    task automatic t_zero();
        go(0, 1, 4, 2, 1000);
        repeat (10) @(negedge clk);
        chk(rx_cnt == 0, "R9 no REQ", rx_cnt, 0);
        chk(done_cycles == 1 && !busy, "R9 done", done_cycles, 1);
        chk(!aborted, "R9 aborted cleared", aborted, 0);
    endtask

    task automatic t_start_busy();
        go(5, 2, 4, 9, 1000);
        repeat (10) @(negedge clk);
        xfer_len = 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(5000);
        chk(rx_cnt == 5, "R10 length kept", rx_cnt, 5);
        check_data(5, 9, "R10 data kept");
        chk(done_cycles == 1, "R10 single done", done_cycles, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic(10, 6, 1);
        t_basic(3, 9, 2);
        t_basic(0, 4, 3);
        t_throttle();
        t_fall_edge();
        t_drain();
        t_abort(6, 2, 2, "R8 room wait");
        t_zero();
        t_abort(2, 4, 2, "R8 drain wait");
        t_start_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule